// File: doc/BRIEF.md
# Multicycle Issue Hazard Controller

This block sits in the decode stage of an in-order pipeline whose execution units each have their own fixed latency. Every cycle it looks at one decoded instruction: its unit class, an optional destination register and up to two source registers. It decides in the same cycle whether the instruction issues or stalls. It also reports, per unit, whether that unit could accept a destination-writing instruction in the current cycle.

To make that decision it keeps three kinds of state. The first is a busy countdown for the divider, which is not pipelined. The second is a shifting map of the future cycles in which the single register-file write port is already claimed. The third is, for every architectural register, a countdown to the cycle in which its pending result becomes readable. These are updated only when an instruction actually issues. A stalled instruction leaves them untouched. The datapath, the forwarding network and the arithmetic itself belong to other blocks.

Unit codes on `in_unit`: 0 = integer ALU (latency 1), 1 = memory (latency 2), 2 = FP add (latency 4), 3 = FP multiply (latency 7), 4 = FP divide (latency 25, one new divide every 25 cycles). An instruction that issues in cycle t writes its result in cycle t+L. A reader of that register may issue in cycle t+L at the earliest.

Top module: `issue_hazard_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all tracking state. In the first cycle after reset, every bit of `unit_ready` is 1 and any valid instruction issues.
- R2: Independent instructions whose write cycles differ issue on consecutive cycles and are in flight together in different pipelined units.
- R3: A divide (unit 4) that issues in cycle t makes any further divide stall in cycles t+1 to t+24. A further divide may issue in cycle t+25.
- R4: An instruction with a destination, of latency L, offered in cycle c stalls when an already issued instruction writes back in cycle c+L.
- R5: An instruction with a destination, of latency L, offered in cycle c stalls when an issued instruction to the same register writes back in cycle c+L or later.
- R6: An instruction that reads an enabled source register stalls in every cycle before the cycle in which that register's pending producer writes back.
- R7: A stalled instruction changes no tracking state. A divide that stalls and is withdrawn does not delay later divides. A destination that stalls and is withdrawn does not block later readers.
- R8: An instruction with `in_has_dest` = 0 is exempt from the write-port check (R4) and the same-destination check (R5), but still obeys the read check (R6).
- R9: `unit_ready[u]` is 1 exactly when no issued write lands in cycle c+L(u) and, for u = 4, the divider is free.
- R10: With `in_valid` = 0 both `issue` and `stall` are 0, and the offered fields change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A decoded instruction is offered this cycle |
| in_unit | input | 3 | Unit class code (0..4) |
| in_has_dest | input | 1 | Instruction writes a destination register |
| in_dest | input | 5 | Destination register |
| in_src_a_en | input | 1 | First source is read |
| in_src_a | input | 5 | First source register |
| in_src_b_en | input | 1 | Second source is read |
| in_src_b | input | 5 | Second source register |
| issue | output | 1 | Instruction issues this cycle |
| stall | output | 1 | Instruction is held in decode this cycle |
| unit_ready | output | 5 | Per-unit acceptance flag, bit index = unit code |

## Verification
Several hazard checks can hit the same offered instruction in one cycle. A divide can meet a busy divider while its source is still pending. A same-register write with a short latency can collide with the write port and also fall before the older write. Random stimulus confined to four registers, with mixed units, produces these overlaps often. Directed sequences place the write-port and same-destination collisions on exact cycles. An independent model in the bench keeps absolute ready cycles, claimed write cycles and the divider free cycle. It judges `issue`, `stall` and every `unit_ready` bit in every cycle, and tags each check with the first hazard that applies.

// File: rtl/ihc_pkg.sv
package ihc_pkg;
    localparam int NUM_UNITS = 5;

    typedef enum logic [2:0] {
        U_ALU  = 3'd0,
        U_MEM  = 3'd1,
        U_FADD = 3'd2,
        U_FMUL = 3'd3,
        U_FDIV = 3'd4
    } unit_e;
endpackage

// File: rtl/ihc_wb_reserve.sv
module ihc_wb_reserve #(
    parameter int DEPTH = 26,
    parameter int NU    = 5,
    parameter int LW    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] probe [NU],
    output logic [NU-1:0] taken,
    input  logic          set_en,
    input  logic [LW-1:0] set_lat
);
    typedef struct packed {
        logic [DEPTH-1:0] slot;
    } wb_state_t;

    wb_state_t st_d, st_q;

    for (genvar g = 0; g < NU; g++) begin : g_probe
        assign taken[g] = st_q.slot[probe[g]];
    end

    always_comb begin
        st_d.slot = st_q.slot >> 1;
        if (set_en) begin
            st_d.slot[LW'(set_lat - 1'b1)] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R4
    wb_no_collide_chk: assert property (@(posedge clk) disable iff (rst)
        set_en |-> !st_q.slot[set_lat]);
endmodule

// File: rtl/ihc_scoreboard.sv
module ihc_scoreboard #(
    parameter int NREGS = 32,
    parameter int RW    = 5,
    parameter int LW    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [RW-1:0] rd_a,
    input  logic [RW-1:0] rd_b,
    input  logic [RW-1:0] rd_dest,
    output logic [LW-1:0] cnt_a,
    output logic [LW-1:0] cnt_b,
    output logic [LW-1:0] cnt_dest,
    input  logic          upd_en,
    input  logic [RW-1:0] upd_reg,
    input  logic [LW-1:0] upd_val
);
    typedef struct packed {
        logic [NREGS-1:0][LW-1:0] cnt;
    } sb_state_t;

    sb_state_t st_d, st_q;

    assign cnt_a    = st_q.cnt[rd_a];
    assign cnt_b    = st_q.cnt[rd_b];
    assign cnt_dest = st_q.cnt[rd_dest];

    always_comb begin
        st_d = st_q;
        for (int r = 0; r < NREGS; r++) begin
            if (st_q.cnt[r] != '0) st_d.cnt[r] = st_q.cnt[r] - 1'b1;
        end
        if (upd_en) st_d.cnt[upd_reg] = upd_val;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R5
    waw_order_chk: assert property (@(posedge clk) disable iff (rst)
        upd_en |-> (st_q.cnt[upd_reg] <= upd_val));
endmodule

// File: rtl/ihc_div_busy.sv
module ihc_div_busy #(
    parameter int II = 25,
    parameter int LW = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic free
);
    typedef struct packed {
        logic [LW-1:0] busy;
    } div_state_t;

    div_state_t st_d, st_q;

    assign free = (st_q.busy == '0);

    always_comb begin
        st_d = st_q;
        if (st_q.busy != '0) st_d.busy = st_q.busy - 1'b1;
        if (start)           st_d.busy = LW'(II - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R3
    div_idle_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> (st_q.busy == '0));
endmodule

// File: rtl/issue_hazard_ctrl.sv
module issue_hazard_ctrl #(
    parameter int NREGS    = 32,
    parameter int LAT_ALU  = 1,
    parameter int LAT_MEM  = 2,
    parameter int LAT_FADD = 4,
    parameter int LAT_FMUL = 7,
    parameter int LAT_FDIV = 25,
    parameter int DIV_II   = 25,
    parameter int WB_DEPTH = 26
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            in_valid,
    input  logic [2:0]                      in_unit,
    input  logic                            in_has_dest,
    input  logic [$clog2(NREGS)-1:0]        in_dest,
    input  logic                            in_src_a_en,
    input  logic [$clog2(NREGS)-1:0]        in_src_a,
    input  logic                            in_src_b_en,
    input  logic [$clog2(NREGS)-1:0]        in_src_b,
    output logic                            issue,
    output logic                            stall,
    output logic [ihc_pkg::NUM_UNITS-1:0]   unit_ready
);
    import ihc_pkg::*;

    localparam int RW = $clog2(NREGS);
    localparam int LW = $clog2(WB_DEPTH + 1);

    function automatic logic [LW-1:0] lat_of(input logic [2:0] u);
        case (u)
            U_MEM:   return LW'(LAT_MEM);
            U_FADD:  return LW'(LAT_FADD);
            U_FMUL:  return LW'(LAT_FMUL);
            U_FDIV:  return LW'(LAT_FDIV);
            default: return LW'(LAT_ALU);
        endcase
    endfunction

    logic [LW-1:0]        probe [NUM_UNITS];
    logic [NUM_UNITS-1:0] wb_taken;
    logic [LW-1:0]        cnt_a, cnt_b, cnt_dest;
    logic                 div_free;
    logic [LW-1:0]        lat_new;
    logic [2:0]           unit_idx;
    logic                 struct_ok, port_ok, waw_ok, raw_ok;

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_ready
        assign probe[g]      = lat_of(3'(g));
        assign unit_ready[g] = !wb_taken[g] && ((g != int'(U_FDIV)) || div_free);
    end

    always_comb begin
        lat_new   = lat_of(in_unit);
        unit_idx  = (in_unit < 3'(NUM_UNITS)) ? in_unit : 3'(U_ALU);
        struct_ok = (in_unit != U_FDIV) || div_free;
        port_ok   = !in_has_dest || !wb_taken[unit_idx];
        waw_ok    = !in_has_dest || (cnt_dest < lat_new);
        raw_ok    = !(in_src_a_en && cnt_a != '0) && !(in_src_b_en && cnt_b != '0);
        issue     = in_valid && struct_ok && port_ok && waw_ok && raw_ok;
        stall     = in_valid && !issue;
    end

    ihc_wb_reserve #(.DEPTH(WB_DEPTH), .NU(NUM_UNITS), .LW(LW)) u_wb (
        .clk     (clk),
        .rst     (rst),
        .probe   (probe),
        .taken   (wb_taken),
        .set_en  (issue && in_has_dest),
        .set_lat (lat_new)
    );

    ihc_scoreboard #(.NREGS(NREGS), .RW(RW), .LW(LW)) u_sb (
        .clk      (clk),
        .rst      (rst),
        .rd_a     (in_src_a),
        .rd_b     (in_src_b),
        .rd_dest  (in_dest),
        .cnt_a    (cnt_a),
        .cnt_b    (cnt_b),
        .cnt_dest (cnt_dest),
        .upd_en   (issue && in_has_dest),
        .upd_reg  (in_dest),
        .upd_val  (LW'(lat_new - 1'b1))
    );

    ihc_div_busy #(.II(DIV_II), .LW(LW)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (issue && (in_unit == U_FDIV)),
        .free  (div_free)
    );

    // R6
    raw_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (issue && in_src_a_en) |-> (cnt_a == '0));
endmodule

// File: tb/test_issue_hazard_ctrl.sv
module test_issue_hazard_ctrl;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst, v, hd, sa_en, sb_en;
    logic [2:0] unit;
    logic [4:0] d, sa, sb;
    logic       issue, stall;
    logic [4:0] unit_ready;

    issue_hazard_ctrl i_issue_hazard_ctrl (
        .clk(clk), .rst(rst), .in_valid(v), .in_unit(unit), .in_has_dest(hd),
        .in_dest(d), .in_src_a_en(sa_en), .in_src_a(sa), .in_src_b_en(sb_en),
        .in_src_b(sb), .issue(issue), .stall(stall), .unit_ready(unit_ready)
    );

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0, last_issue;
    int ready_at [32];
    int wb_at [64];
    int div_free_at;

    function automatic int lat(int u);
        case (u)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 7;
            default: return 25;
        endcase
    endfunction

    function automatic bit wb_hit(int c);
        return wb_at[c % 64] == c;
    endfunction

    task automatic chk(bit act, bit exp, string tag, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b cyc=%0d", tag, what, act, exp, cyc);
        end
    endtask

    task automatic predict(output bit iss, output string tag);
        int L = lat(int'(unit));
        iss = 0;
        if (!v) tag = "R10";
        else if (unit == 3'd4 && cyc < div_free_at) tag = "R3";
        else if ((sa_en && ready_at[sa] > cyc) || (sb_en && ready_at[sb] > cyc)) tag = "R6";
        else if (hd && ready_at[d] >= cyc + L) tag = "R5";
        else if (hd && wb_hit(cyc + L)) tag = "R4";
        else begin
            iss = 1;
            tag = hd ? "R2" : "R8";
        end
    endtask

    task automatic step(bit iv, int u, bit ihd, int id, bit iae, int ia, bit ibe, int ib);
        bit p;
        string tag;
        @(negedge clk);
        v = iv; unit = 3'(u); hd = ihd; d = 5'(id);
        sa_en = iae; sa = 5'(ia); sb_en = ibe; sb = 5'(ib);
        #1;
        predict(p, tag);
        chk(issue, p, tag, "issue");
        chk(stall, iv && !p, tag, "stall");
        for (int k = 0; k < 5; k++)
            chk(unit_ready[k], !wb_hit(cyc + lat(k)) && (k != 4 || cyc >= div_free_at), "R9", "unit_ready");
        last_issue = issue;
        if (p) begin
            if (ihd) begin
                ready_at[id] = cyc + lat(u);
                wb_at[(cyc + lat(u)) % 64] = cyc + lat(u);
            end
            if (u == 4) div_free_at = cyc + 25;
        end
        @(posedge clk);
        cyc++;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic xchk(bit exp, string tag);
        chk(last_issue, exp, tag, "directed issue");
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 32; r++) ready_at[r] = -1;
        for (int r = 0; r < 64; r++) wb_at[r] = -1;
        div_free_at = 0;
        void'($urandom(32'd4242));
        rst = 1; v = 0; unit = 0; hd = 0; d = 0; sa_en = 0; sa = 0; sb_en = 0; sb = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        chk(unit_ready == 5'h1f, 1'b1, "R1", "unit_ready after reset");

        // R1: first instruction after reset issues
        step(1, 4, 1, 3, 1, 3, 0, 0); xchk(1, "R1");
        idle(26);

        // R2: four independent units back to back
        step(1, 3, 1, 1, 0, 0, 0, 0); xchk(1, "R2");
        step(1, 1, 1, 2, 0, 0, 0, 0); xchk(1, "R2");
        step(1, 2, 1, 3, 0, 0, 0, 0); xchk(1, "R2");
        step(1, 0, 1, 4, 0, 0, 0, 0); xchk(1, "R2");
        idle(10);

        // R3: divider structural hazard
        step(1, 4, 1, 5, 0, 0, 0, 0); xchk(1, "R3");
        step(1, 4, 1, 6, 0, 0, 0, 0); xchk(0, "R3");
        for (int k = 2; k < 25; k++) step(1, 4, 1, 6, 0, 0, 0, 0);
        xchk(0, "R3");
        step(1, 4, 1, 6, 0, 0, 0, 0); xchk(1, "R3");

        // R7: withdrawn stalled divide leaves divider timing alone
        for (int k = 0; k < 3; k++) step(1, 4, 1, 7, 0, 0, 0, 0);
        xchk(0, "R7");
        idle(21);
        step(1, 4, 1, 7, 0, 0, 0, 0); xchk(1, "R7");
        idle(26);

        // R7: withdrawn stalled destination does not block readers
        step(1, 3, 1, 20, 0, 0, 0, 0);
        step(1, 3, 1, 13, 1, 20, 0, 0); xchk(0, "R6");
        step(1, 0, 0, 0, 1, 13, 0, 0);  xchk(1, "R7");
        idle(10);

        // R4: write-port collision and R9 flag
        step(1, 2, 1, 7, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0, 0);
        step(1, 1, 1, 8, 0, 0, 0, 0); xchk(0, "R4");
        chk(unit_ready[1], 1'b0, "R9", "mem ready during collision");
        step(1, 1, 1, 8, 0, 0, 0, 0); xchk(1, "R4");
        idle(10);

        // R8: no-destination exempt from port and WAW, still RAW
        step(1, 2, 1, 15, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0, 0);
        step(1, 1, 0, 15, 0, 0, 0, 0); xchk(1, "R8");
        step(1, 1, 0, 0, 1, 15, 0, 0); xchk(0, "R8");
        step(1, 1, 0, 0, 1, 15, 0, 0); xchk(1, "R8");
        idle(10);

        // R5: same destination, shorter latency, completes earlier
        step(1, 3, 1, 9, 0, 0, 0, 0);
        step(1, 0, 1, 9, 0, 0, 0, 0); xchk(0, "R5");
        for (int k = 0; k < 5; k++) step(1, 0, 1, 9, 0, 0, 0, 0);
        xchk(0, "R5");
        step(1, 0, 1, 9, 0, 0, 0, 0); xchk(1, "R5");
        idle(10);

        // R6: long-latency producer stalls reader for 6 cycles
        step(1, 3, 1, 10, 0, 0, 0, 0);
        for (int k = 0; k < 6; k++) step(1, 0, 1, 11, 0, 0, 1, 10);
        xchk(0, "R6");
        step(1, 0, 1, 11, 0, 0, 1, 10); xchk(1, "R6");
        step(1, 0, 1, 12, 0, 0, 0, 0);
        step(1, 0, 1, 13, 1, 12, 0, 0); xchk(1, "R6");
        idle(10);

        // R10: invalid divide is ignored
        step(0, 4, 1, 5, 0, 0, 0, 0); xchk(0, "R10");
        chk(stall, 1'b0, "R10", "stall when invalid");
        step(1, 4, 1, 5, 0, 0, 0, 0); xchk(1, "R10");
        idle(26);

        // random mix over four registers
        for (int n = 0; n < 4000; n++) begin
            int u = int'($urandom % 5);
            if (u == 4 && ($urandom % 4) != 0) u = int'($urandom % 4);
            step(($urandom % 5) != 0, u, ($urandom % 4) != 0, int'($urandom % 4),
                 $urandom % 2, int'($urandom % 4), $urandom % 2, int'($urandom % 4));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule